// File: doc/BRIEF.md
# Operational State Controller with Settling Handshake

This block owns the operating state of a serial peripheral core. Software requests a state by writing a 2-bit code. The block drops its valid flag and waits a fixed settling interval. It then applies the new state and raises valid again. The three held states are idle-reset, run and pause. In run the shifter may move data. In pause the shifter is frozen and the FIFO contents are kept. On entry to reset the block issues a one-cycle flush that empties both FIFOs and zeroes the transfer counters.

Pause is deliberately hard to leave for reset. A plain reset code is ignored in pause. The clear code must instead be written twice in a row: the first write only arms the transition and the second one launches it. A separate soft-reset strobe bypasses all of this and forces reset on the next edge.

Top module: `opstate_ctrl`

## Requirements
- R1: The read word carries the state in bits 1:0 (0 = reset, 1 = run, 3 = pause), the valid flag in bit 2, and zeros in every higher bit. After hardware reset it reads state 0 with valid high. The state field never shows code 2.
- R2: A write is accepted only while valid is high. An accepted write drops valid for exactly SETTLE cycles (4 by default), and the old state stays visible during that time. The new state and valid = 1 then appear together. Writes made while valid is low have no effect.
- R3: From reset or run, code 1 settles to run and code 3 settles to pause. Code 0 settles to reset, and this also applies when the block is already in reset.
- R4: In pause, a write of code 0 is ignored: valid stays high and the state stays pause.
- R5: In pause, the first write of code 2 only arms the transition, with valid staying high. A second consecutive write of code 2 settles to reset. Any other accepted write in between disarms it.
- R6: Outside pause, a write of code 2 is ignored.
- R7: A soft-reset strobe forces state reset with valid high on the next edge. It cancels any settling in progress and any armed clear, and it takes precedence over a state write in the same cycle.
- R8: Each entry to reset, whether settled or forced, pulses flush_all high for exactly one cycle, together with the new state. shift_en is high exactly while the state is run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the state field |
| wr_code | input | 2 | Requested state code |
| soft_rst_wr | input | 1 | Write-one strobe of the soft-reset register |
| rd_data | output | REG_W | Read view: state, valid flag, zero upper bits |
| shift_en | output | 1 | Shifter enable, high in run |
| flush_all | output | 1 | One-cycle FIFO flush and counter clear |

## Verification
The bench targets the pause exit in particular. It checks that a lone clear or a reset code in pause does not move the state. It also checks that an intervening write disarms a pending clear; a design that kept the arm would reach reset one write too early. The settle window is sampled on every cycle, so a counter that is off by one shows up as valid returning a cycle early or late. A design that latched a second write made during settling ends in the wrong state. The soft-reset tests cover cancelling a settle and an arm; a design that resumed the old settle would leave reset without being asked.

// File: rtl/opstate_pkg.sv
// Shared state encoding for the operational state controller.
// Assumes the encoding is fixed by software: codes are visible on the bus.
package opstate_pkg;
    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_RUN   = 2'd1,
        ST_CLEAR = 2'd2,
        ST_PAUSE = 2'd3
    } opst_e;
endpackage

// File: rtl/opstate_decode.sv
// Write decoder: turns a state-field write into a settle request, an arm
// update, or nothing. Purely combinational.
// Assumes the caller gates soft reset separately (soft reset wins outside).
module opstate_decode
    import opstate_pkg::*;
(
    input  opst_e      cur_state,
    input  logic       armed,
    input  logic       valid,
    input  logic       wr_en,
    input  logic [1:0] wr_code,
    output logic       start,
    output opst_e      target,
    output logic       arm_set,
    output logic       arm_clr
);
    // Decide the effect of one write against the settled state.
    always_comb begin
        start   = 1'b0;
        target  = cur_state;
        arm_set = 1'b0;
        arm_clr = 1'b0;
        if (wr_en && valid) begin
            case (opst_e'(wr_code))
                ST_RESET: begin
                    arm_clr = 1'b1;
                    if (cur_state != ST_PAUSE) begin
                        start  = 1'b1;
                        target = ST_RESET;
                    end
                end
                ST_RUN, ST_PAUSE: begin
                    arm_clr = 1'b1;
                    start   = 1'b1;
                    target  = opst_e'(wr_code);
                end
                default: begin
                    if (cur_state == ST_PAUSE) begin
                        if (armed) begin
                            start   = 1'b1;
                            target  = ST_RESET;
                            arm_clr = 1'b1;
                        end else begin
                            arm_set = 1'b1;
                        end
                    end else begin
                        arm_clr = 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/opstate_settle.sv
// Settling timer: after start it stays busy for SETTLE cycles, then pulses
// done in its final busy cycle. Cancel aborts it at once.
// Assumes start is never raised while busy.
module opstate_settle #(
    parameter int SETTLE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cancel,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count down the settling window.
    always_ff @(posedge clk) begin
        if (!rst_n || cancel) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= LOAD;
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = busy && (cnt_q == '0) && !cancel;

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q <= LOAD)) else $error("timer out of range"); // R2
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy) else $error("busy after done"); // R2
endmodule

// File: rtl/opstate_ctrl.sv
// Operational state controller. Holds the settled state, the valid flag and
// the clear-arm bit; sequences transitions through the settle timer and
// issues a flush pulse whenever reset is entered.
// Assumes single-cycle write strobes and one clock domain.
module opstate_ctrl
    import opstate_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int SETTLE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_code,
    input  logic             soft_rst_wr,
    output logic [REG_W-1:0] rd_data,
    output logic             shift_en,
    output logic             flush_all
);
    localparam int PAD_W = REG_W - 3;

    opst_e state_q, tgt_q, target;
    logic  valid_q, armed_q, flush_q;
    logic  start, arm_set, arm_clr, busy, done, start_eff;

    opstate_decode u_dec (
        .cur_state (state_q),
        .armed     (armed_q),
        .valid     (valid_q),
        .wr_en     (wr_en),
        .wr_code   (wr_code),
        .start     (start),
        .target    (target),
        .arm_set   (arm_set),
        .arm_clr   (arm_clr)
    );

    assign start_eff = start && !soft_rst_wr;

    opstate_settle #(.SETTLE(SETTLE)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_eff),
        .cancel (soft_rst_wr),
        .busy   (busy),
        .done   (done)
    );

    // Hold settled state, valid flag, clear-arm and flush pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
            tgt_q   <= ST_RESET;
            valid_q <= 1'b1;
            armed_q <= 1'b0;
            flush_q <= 1'b0;
        end else if (soft_rst_wr) begin
            state_q <= ST_RESET;
            valid_q <= 1'b1;
            armed_q <= 1'b0;
            flush_q <= 1'b1;
        end else begin
            flush_q <= 1'b0;
            if (start) begin
                valid_q <= 1'b0;
                tgt_q   <= target;
            end
            if (done) begin
                state_q <= tgt_q;
                valid_q <= 1'b1;
                flush_q <= (tgt_q == ST_RESET);
            end
            if (arm_set)      armed_q <= 1'b1;
            else if (arm_clr) armed_q <= 1'b0;
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_data = {{PAD_W{1'b0}}, valid_q, state_q};
        end else begin : g_nopad
            assign rd_data = {valid_q, state_q};
        end
    endgenerate

    assign shift_en  = (state_q == ST_RUN);
    assign flush_all = flush_q;

    AST_NO_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_CLEAR) else $error("clear code held as state"); // R1
    AST_STATE_MOVES_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state_q) |-> valid_q) else $error("state moved while settling"); // R2
    AST_ZERO_IGNORED_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && valid_q && state_q == ST_PAUSE && wr_code == 2'd0 && !soft_rst_wr)
        |=> (valid_q && state_q == ST_PAUSE)) else $error("zero left pause"); // R4
    AST_FIRST_CLEAR_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && valid_q && state_q == ST_PAUSE && wr_code == 2'd2 && !armed_q && !soft_rst_wr)
        |=> (valid_q && armed_q && state_q == ST_PAUSE)) else $error("first clear not arm-only"); // R5
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_wr |=> (state_q == ST_RESET && valid_q && flush_all && !busy)) else $error("soft reset"); // R7
    AST_FLUSH_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |-> (state_q == ST_RESET && valid_q)) else $error("flush outside reset"); // R8
endmodule

// File: tb/tb_opstate_ctrl.sv
`timescale 1ns/100ps
module tb_opstate_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_code = 2'd0;
    logic       soft_rst_wr = 1'b0;
    logic [7:0] rd_data;
    logic       shift_en, flush_all;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [1:0] cur = 2'd0;

    always #2.5 clk = ~clk;

    opstate_ctrl #(.REG_W(8), .SETTLE(4)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code),
        .soft_rst_wr(soft_rst_wr), .rd_data(rd_data),
        .shift_en(shift_en), .flush_all(flush_all)
    );

    // Entry: [5:4] code, [3] valid drops, [2] flush expected, [1:0] final state
    localparam int NV = 15;
    localparam logic [5:0] VEC [NV] = '{
        6'b01_1_0_01, 6'b11_1_0_11, 6'b00_0_0_11, 6'b10_0_0_11,
        6'b10_1_1_00, 6'b10_0_0_00, 6'b11_1_0_11, 6'b10_0_0_11,
        6'b11_1_0_11, 6'b10_0_0_11, 6'b10_1_1_00, 6'b01_1_0_01,
        6'b10_0_0_01, 6'b00_1_1_00, 6'b00_1_1_00
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Issue one write and check the whole settle window cycle by cycle.
    task automatic step(input logic [1:0] code, input bit drop, input bit fl,
                        input logic [1:0] exp, input string tag);
        @(negedge clk); wr_en = 1'b1; wr_code = code;
        @(posedge clk); @(negedge clk); wr_en = 1'b0;
        if (drop) begin
            for (int i = 0; i < 4; i++) begin
                if (i > 0) @(negedge clk);
                chk(rd_data == {6'd0, cur} && !flush_all, {tag, " R2 settle"},
                    {flush_all, rd_data}, {6'd0, cur});
            end
            @(negedge clk);
        end
        chk(rd_data == {5'd0, 1'b1, exp}, tag, rd_data, {5'd0, 1'b1, exp});
        chk(flush_all == fl, {tag, " R8 flush"}, flush_all, fl);
        chk(shift_en == (exp == 2'd1), {tag, " R8 shift"}, shift_en, exp == 2'd1);
        cur = exp;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset view
        chk(rd_data == 8'h04 && !shift_en && !flush_all, "R1 reset state", rd_data, 8'h04);

        // Table: R3 R4 R5 R6 R8
        for (int k = 0; k < NV; k++)
            step(VEC[k][5:4], VEC[k][3], VEC[k][2], VEC[k][1:0], $sformatf("R3/R4/R5/R6 vec %0d", k));

        // R2: write during settling ignored
        @(negedge clk); wr_en = 1'b1; wr_code = 2'd1;
        @(negedge clk); wr_code = 2'd3;
        @(negedge clk); wr_en = 1'b0;
        repeat (6) @(negedge clk);
        chk(rd_data == 8'h05, "R2 busy write ignored", rd_data, 8'h05);
        cur = 2'd1;

        // R7: soft reset mid-settle cancels it
        @(negedge clk); wr_en = 1'b1; wr_code = 2'd3;
        @(negedge clk); wr_en = 1'b0; soft_rst_wr = 1'b1;
        @(negedge clk); soft_rst_wr = 1'b0;
        chk(rd_data == 8'h04 && flush_all, "R7 soft reset applied", {flush_all, rd_data}, 9'h104);
        repeat (6) @(negedge clk);
        chk(rd_data == 8'h04 && !flush_all, "R7 settle cancelled", {flush_all, rd_data}, 9'h004);
        cur = 2'd0;

        // R7: soft reset wins over same-cycle write and clears the arm
        step(2'd3, 1'b1, 1'b0, 2'd3, "R7 to pause");
        step(2'd2, 1'b0, 1'b0, 2'd3, "R7 arm");
        @(negedge clk); soft_rst_wr = 1'b1; wr_en = 1'b1; wr_code = 2'd1;
        @(negedge clk); soft_rst_wr = 1'b0; wr_en = 1'b0;
        chk(rd_data == 8'h04, "R7 precedence", rd_data, 8'h04);
        cur = 2'd0;
        step(2'd3, 1'b1, 1'b0, 2'd3, "R7 pause again");
        step(2'd2, 1'b0, 1'b0, 2'd3, "R7 arm was cleared");

        // R1: hardware reset from pause
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk(rd_data == 8'h04 && !flush_all, "R1 hard reset from pause", rd_data, 8'h04);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule